// File: doc/BRIEF.md
# LCD Controller Register Interface

This block is the register slave of a colour LCD controller. A host reaches it over a simple 32-bit bus that carries a 12-bit byte address, a write enable, write data and read data. Read data is registered. The block holds the panel timing words, the frame base addresses for the upper and lower panel, the interrupt mask and the control word. It keeps a raw interrupt status that can be read directly or through the mask, and cleared with a write-one-to-clear command. A read-only window returns identification bytes.

Accesses to the palette window go to a 128-word palette store and are also forwarded on a registered write port that feeds the pixel pipeline. From the register contents the block decodes panel width, panel height, colour depth and an effective enable; the display datapath consumes these. A build-time variant swaps which of two offsets writes the mask and which writes the control word.

Top module: `lcdc_regs`

## Requirements
- R1: After synchronous reset, every register and the interrupt status are zero. `bus_rdata` and `irq` are 0, `panel_width` is 16, `panel_height` is 1 and `panel_en` is 0.
- R2: Reads have one cycle of latency: `bus_rdata` presents the value selected by the address of the previous cycle. Word offsets 0x00, 0x04, 0x08 and 0x0C read timing words 0 to 3. Offset 0x10 reads the upper base and 0x14 the lower base. Offset 0x18 reads the mask (zero-extended) and 0x1C the control word. Offsets 0x2C and 0x30 read the upper and lower base again. Address bits 1:0 are ignored.
- R3: `panel_width` equals ((timing0 & 0xFC) + 4) * 4. It ranges from 16 to 1024.
- R4: `panel_height` equals (timing1 & 0x3FF) + 1. It ranges from 1 to 1024.
- R5: `panel_en` is 1 only when control bit 0 and control bit 11 are both 1. `panel_depth` equals control bits 3:1.
- R6: A 1 on bit k of `stat_set` sets status bit k at the next clock edge. Offset 0x20 reads the raw status. Offset 0x24 reads the status ANDed with the mask.
- R7: A write to offset 0x28 clears every status bit that is 1 in the written value. When the same bit is also being set in that cycle, the set wins. Offset 0x28 reads zero.
- R8: `irq` is 1 in the cycle after one in which any status bit and its mask bit are both 1, and is 0 otherwise.
- R9: A read in 0xFE0 to 0xFFF returns one byte zero-extended, chosen by address bits 4:2 from the sequence 0x10, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1. Writes there change nothing.
- R10: Offsets 0x200 to 0x3FF address a 128-word palette store, indexed by address bits 8:2, for both write and read. A read in the same cycle as a write to the same word returns the old word. Each palette write appears on `pal_wr_en`/`pal_wr_idx`/`pal_wr_data` in the following cycle.
- R11: Every other offset reads zero, and writes to it change no register, no status and no palette word. The same holds for writes to 0x20, 0x24, 0x2C and 0x30.
- R12: With `SWAP_MASK_CTRL` set, a write to 0x18 updates the control word and a write to 0x1C updates the mask. Reads keep their normal offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte address |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the address |
| stat_set | input | NIRQ | Per-bit interrupt status set requests |
| irq | output | 1 | Registered OR of masked status |
| pal_wr_en | output | 1 | Forwarded palette write strobe |
| pal_wr_idx | output | PAL_AW | Forwarded palette word index |
| pal_wr_data | output | 32 | Forwarded palette word |
| panel_width | output | GEOM_W | Decoded width in pixels |
| panel_height | output | GEOM_W | Decoded height in lines |
| panel_depth | output | 3 | Colour depth code |
| panel_en | output | 1 | Effective enable |

## Verification
Assertions check the following on every cycle: the interrupt line after masked status, the clear command removing bits that are not being set, the enable that follows a control write with both gate bits set, the forwarding of palette writes, and the zero read of unmapped offsets. The bench's reference model is the only thing that shows the width and height arithmetic at both range ends, and the exact identification byte order. It also shows read-before-write on the palette, the set-over-clear rule, and that stray writes leave state untouched. The swapped mask/control variant is shown only by a second instance driven through directed writes and reads.

// File: rtl/lcdc_regs_pkg.sv
package lcdc_regs_pkg;

  typedef enum logic {SRC_REG, SRC_PAL} rd_src_e;

  localparam logic [9:0] SLOT_UBASE  = 10'd4;
  localparam logic [9:0] SLOT_LBASE  = 10'd5;
  localparam logic [9:0] SLOT_SIX    = 10'd6;
  localparam logic [9:0] SLOT_SEVEN  = 10'd7;
  localparam logic [9:0] SLOT_RAW    = 10'd8;
  localparam logic [9:0] SLOT_MSKD   = 10'd9;
  localparam logic [9:0] SLOT_CLR    = 10'd10;
  localparam logic [9:0] SLOT_UCUR   = 10'd11;
  localparam logic [9:0] SLOT_LCUR   = 10'd12;

  function automatic logic [7:0] id_byte(input logic [2:0] idx);
    case (idx)
      3'd0:    id_byte = 8'h10;
      3'd1:    id_byte = 8'h11;
      3'd2:    id_byte = 8'h04;
      3'd3:    id_byte = 8'h00;
      3'd4:    id_byte = 8'h0D;
      3'd5:    id_byte = 8'hF0;
      3'd6:    id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction

endpackage

// File: rtl/lcdc_pal_ram.sv
module lcdc_pal_ram #(
  parameter int DEPTH = 128,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  // read-first single-clock store, infers block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/lcdc_irq_ctrl.sv
module lcdc_irq_ctrl #(
  parameter int NIRQ = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NIRQ-1:0] set,
  input  logic            clr_en,
  input  logic [NIRQ-1:0] clr_val,
  input  logic            mask_we,
  input  logic [NIRQ-1:0] mask_val,
  output logic [NIRQ-1:0] status,
  output logic [NIRQ-1:0] mask,
  output logic            irq
);
  logic [NIRQ-1:0] clr_bits;
  assign clr_bits = clr_en ? clr_val : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      mask   <= '0;
      irq    <= 1'b0;
    end else begin
      status <= (status & ~clr_bits) | set;
      if (mask_we) mask <= mask_val;
      irq <= |(status & mask);
    end
  end

  p_clear_wins_r7: assert property (@(posedge clk) disable iff (rst)
    clr_en |=> ((status & $past(clr_val) & ~$past(set)) == '0));

  p_irq_follows_r8: assert property (@(posedge clk) disable iff (rst)
    (|(status & mask)) |=> irq);

  p_irq_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    ((status & mask) == '0) |=> !irq);
endmodule

// File: rtl/lcdc_geom.sv
module lcdc_geom #(
  parameter int GEOM_W = 11
) (
  input  logic [31:0]       tim0,
  input  logic [31:0]       tim1,
  input  logic [31:0]       ctrl,
  output logic [GEOM_W-1:0] width,
  output logic [GEOM_W-1:0] height,
  output logic [2:0]        depth,
  output logic              en
);
  logic [GEOM_W-1:0] ppl_units;
  assign ppl_units = GEOM_W'(tim0[7:2]) + GEOM_W'(1);
  assign width     = ppl_units << 4;
  assign height    = GEOM_W'(tim1[9:0]) + GEOM_W'(1);
  assign depth     = ctrl[3:1];
  assign en        = ctrl[0] & ctrl[11];
endmodule

// File: rtl/lcdc_regs.sv
module lcdc_regs
  import lcdc_regs_pkg::*;
#(
  parameter int NIRQ           = 5,
  parameter int PAL_DEPTH      = 128,
  parameter int PAL_AW         = $clog2(PAL_DEPTH),
  parameter int GEOM_W         = 11,
  parameter bit SWAP_MASK_CTRL = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [11:0]       bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NIRQ-1:0]   stat_set,
  output logic              irq,
  output logic              pal_wr_en,
  output logic [PAL_AW-1:0] pal_wr_idx,
  output logic [31:0]       pal_wr_data,
  output logic [GEOM_W-1:0] panel_width,
  output logic [GEOM_W-1:0] panel_height,
  output logic [2:0]        panel_depth,
  output logic              panel_en
);
  localparam int NTIM = 4;

  logic [9:0]  widx;
  logic        reg_space, pal_hit, id_hit, unmapped;
  logic        wr_reg, wr_mask, wr_ctrl, wr_clr;
  logic [31:0] tim [NTIM];
  logic [31:0] ubase, lbase, ctrl;
  logic [NIRQ-1:0] status, mask;
  logic [31:0] rd_next, rd_val, pal_q;
  rd_src_e     rd_src;

  assign widx      = bus_addr[11:2];
  assign reg_space = (bus_addr[11:9] == 3'b000);
  assign pal_hit   = (bus_addr[11:9] == 3'b001);
  assign id_hit    = (bus_addr[11:5] == 7'h7F);
  assign unmapped  = !(pal_hit || id_hit || (reg_space && widx <= SLOT_LCUR));
  assign wr_reg    = bus_we && reg_space;
  assign wr_clr    = wr_reg && (widx == SLOT_CLR);

  generate
    if (SWAP_MASK_CTRL) begin : g_swapped
      assign wr_ctrl = wr_reg && (widx == SLOT_SIX);
      assign wr_mask = wr_reg && (widx == SLOT_SEVEN);
    end else begin : g_normal
      assign wr_mask = wr_reg && (widx == SLOT_SIX);
      assign wr_ctrl = wr_reg && (widx == SLOT_SEVEN);
    end
  endgenerate

  generate
    for (genvar k = 0; k < NTIM; k++) begin : g_tim
      always_ff @(posedge clk) begin
        if (rst) tim[k] <= '0;
        else if (wr_reg && widx == 10'(k)) tim[k] <= bus_wdata;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      ubase <= '0;
      lbase <= '0;
      ctrl  <= '0;
    end else begin
      if (wr_reg && widx == SLOT_UBASE) ubase <= bus_wdata;
      if (wr_reg && widx == SLOT_LBASE) lbase <= bus_wdata;
      if (wr_ctrl) ctrl <= bus_wdata;
    end
  end

  lcdc_irq_ctrl #(.NIRQ(NIRQ)) u_irq (
    .clk(clk), .rst(rst), .set(stat_set),
    .clr_en(wr_clr), .clr_val(bus_wdata[NIRQ-1:0]),
    .mask_we(wr_mask), .mask_val(bus_wdata[NIRQ-1:0]),
    .status(status), .mask(mask), .irq(irq)
  );

  lcdc_pal_ram #(.DEPTH(PAL_DEPTH), .DW(32)) u_pal (
    .clk(clk), .we(bus_we && pal_hit),
    .waddr(bus_addr[PAL_AW+1:2]), .wdata(bus_wdata),
    .raddr(bus_addr[PAL_AW+1:2]), .rdata(pal_q)
  );

  lcdc_geom #(.GEOM_W(GEOM_W)) u_geom (
    .tim0(tim[0]), .tim1(tim[1]), .ctrl(ctrl),
    .width(panel_width), .height(panel_height),
    .depth(panel_depth), .en(panel_en)
  );

  always_comb begin
    rd_next = '0;
    if (id_hit) begin
      rd_next = {24'd0, id_byte(bus_addr[4:2])};
    end else if (reg_space) begin
      case (widx)
        10'd0, 10'd1, 10'd2, 10'd3: rd_next = tim[widx[1:0]];
        SLOT_UBASE, SLOT_UCUR: rd_next = ubase;
        SLOT_LBASE, SLOT_LCUR: rd_next = lbase;
        SLOT_SIX:   rd_next = 32'(mask);
        SLOT_SEVEN: rd_next = ctrl;
        SLOT_RAW:   rd_next = 32'(status);
        SLOT_MSKD:  rd_next = 32'(status & mask);
        default:    rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_src      <= SRC_REG;
      rd_val      <= '0;
      pal_wr_en   <= 1'b0;
      pal_wr_idx  <= '0;
      pal_wr_data <= '0;
    end else begin
      rd_src      <= pal_hit ? SRC_PAL : SRC_REG;
      rd_val      <= rd_next;
      pal_wr_en   <= bus_we && pal_hit;
      pal_wr_idx  <= bus_addr[PAL_AW+1:2];
      pal_wr_data <= bus_wdata;
    end
  end

  assign bus_rdata = (rd_src == SRC_PAL) ? pal_q : rd_val;

  p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (rst)
    unmapped |=> (bus_rdata == 32'd0));

  p_enable_gate_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_ctrl && bus_wdata[0] && bus_wdata[11]) |=> panel_en);

  p_pal_forward_r10: assert property (@(posedge clk) disable iff (rst)
    (bus_we && pal_hit) |=> (pal_wr_en && pal_wr_data == $past(bus_wdata)));
endmodule

// File: tb/lcdc_regs_bench.sv
`timescale 1ns/1ps
module lcdc_regs_bench;
  localparam int NIRQ = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [NIRQ-1:0] sset = '0;
  logic [31:0] rdata;
  logic        irq, pwe, en;
  logic [6:0]  pidx;
  logic [31:0] pdata;
  logic [10:0] wid, hgt;
  logic [2:0]  dep;

  logic [11:0] s_addr = '0;
  logic        s_we = 1'b0;
  logic [31:0] s_wdata = '0;
  logic [31:0] s_rdata;
  logic        s_irq, s_pwe, s_en;
  logic [6:0]  s_pidx;
  logic [31:0] s_pdata;
  logic [10:0] s_wid, s_hgt;
  logic [2:0]  s_dep;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  lcdc_regs u_lcdc_regs (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
    .bus_rdata(rdata), .stat_set(sset), .irq(irq), .pal_wr_en(pwe),
    .pal_wr_idx(pidx), .pal_wr_data(pdata), .panel_width(wid),
    .panel_height(hgt), .panel_depth(dep), .panel_en(en));

  lcdc_regs #(.SWAP_MASK_CTRL(1'b1)) u_lcdc_regs_swap (
    .clk(clk), .rst(rst), .bus_addr(s_addr), .bus_we(s_we), .bus_wdata(s_wdata),
    .bus_rdata(s_rdata), .stat_set('0), .irq(s_irq), .pal_wr_en(s_pwe),
    .pal_wr_idx(s_pidx), .pal_wr_data(s_pdata), .panel_width(s_wid),
    .panel_height(s_hgt), .panel_depth(s_dep), .panel_en(s_en));

  // reference model
  logic [31:0] m_tim [4];
  logic [31:0] m_ub, m_lb, m_ctrl;
  logic [NIRQ-1:0] m_stat, m_mask;
  logic [31:0] m_pal [128];
  logic [7:0]  id_tab [8] = '{8'h10, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [11:0] a);
    int w = int'(a[11:2]);
    if (a[11:9] == 3'b001) return m_pal[a[8:2]];
    if (a[11:5] == 7'h7F)  return {24'd0, id_tab[a[4:2]]};
    if (a[11:9] != 3'b000) return 32'd0;
    case (w)
      0, 1, 2, 3: return m_tim[w];
      4, 11:      return m_ub;
      5, 12:      return m_lb;
      6:          return 32'(m_mask);
      7:          return m_ctrl;
      8:          return 32'(m_stat);
      9:          return 32'(m_stat & m_mask);
      default:    return 32'd0;
    endcase
  endfunction

  function automatic string rd_tag(input logic [11:0] a);
    if (a[11:9] == 3'b001) return "R10 palette read";
    if (a[11:5] == 7'h7F)  return "R9 id read";
    if (a[11:9] != 3'b000 || a[11:2] > 10'd12) return "R11 unmapped read";
    if (a[11:2] == 10'd8 || a[11:2] == 10'd9) return "R6 status read";
    if (a[11:2] == 10'd10) return "R7 clear slot read";
    return "R2 register read";
  endfunction

  // one bus cycle on the main instance, all outputs checked after the edge
  task automatic step(input logic w, input logic [11:0] a, input logic [31:0] d,
                      input logic [NIRQ-1:0] s);
    logic [31:0] e_rd;
    logic        e_irq;
    logic [NIRQ-1:0] clr;
    @(negedge clk);
    we = w; addr = a; wdata = d; sset = s;
    e_rd  = exp_read(a);
    e_irq = |(m_stat & m_mask);
    clr   = (w && a[11:2] == 10'd10) ? d[NIRQ-1:0] : '0;
    @(posedge clk);
    if (w && a[11:9] == 3'b000) begin
      case (int'(a[11:2]))
        0, 1, 2, 3: m_tim[a[3:2]] = d;
        4: m_ub = d;
        5: m_lb = d;
        6: m_mask = d[NIRQ-1:0];
        7: m_ctrl = d;
        default: ;
      endcase
    end
    if (w && a[11:9] == 3'b001) m_pal[a[8:2]] = d;
    m_stat = (m_stat & ~clr) | s;
    #1;
    chk(rd_tag(a), rdata, e_rd);
    chk("R8 irq", 32'(irq), 32'(e_irq));
    chk("R3 width", 32'(wid), ((m_tim[0] & 32'hFC) + 32'd4) * 32'd4);
    chk("R4 height", 32'(hgt), (m_tim[1] & 32'h3FF) + 32'd1);
    chk("R5 enable", 32'(en), 32'(m_ctrl[0] & m_ctrl[11]));
    chk("R5 depth", 32'(dep), 32'(m_ctrl[3:1]));
    chk("R10 forward strobe", 32'(pwe), 32'(w && a[11:9] == 3'b001));
    if (w && a[11:9] == 3'b001) begin
      chk("R10 forward index", 32'(pidx), 32'(a[8:2]));
      chk("R10 forward data", pdata, d);
    end
  endtask

  task automatic s_step(input logic w, input logic [11:0] a, input logic [31:0] d,
                        input string req, input logic [31:0] exp_rd);
    @(negedge clk);
    s_we = w; s_addr = a; s_wdata = d;
    @(posedge clk);
    #1;
    if (!w) chk(req, s_rdata, exp_rd);
  endtask

  function automatic logic [11:0] rand_addr();
    int c = int'($urandom % 8);
    logic [11:0] a;
    if (c < 4)      a = 12'(($urandom % 13) * 4);
    else if (c < 6) a = 12'h200 + 12'(($urandom % 128) * 4);
    else if (c == 6) a = 12'hFE0 + 12'(($urandom % 8) * 4);
    else if ($urandom % 2 == 0) a = 12'h034 + 12'(($urandom % 115) * 4);
    else a = 12'h400 + 12'(($urandom % 760) * 4);
    return a | 12'($urandom % 4);
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    for (int k = 0; k < 4; k++) m_tim[k] = '0;
    m_ub = '0; m_lb = '0; m_ctrl = '0; m_stat = '0; m_mask = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    // R1 reset state
    chk("R1 rdata", rdata, 32'd0);
    chk("R1 irq", 32'(irq), 32'd0);
    chk("R1 width", 32'(wid), 32'd16);
    chk("R1 height", 32'(hgt), 32'd1);
    chk("R1 enable", 32'(en), 32'd0);
    step(1'b0, 12'h01C, 32'd0, '0);
    step(1'b0, 12'h020, 32'd0, '0);

    // fill palette so every word is known (R10)
    for (int k = 0; k < 128; k++) step(1'b1, 12'h200 + 12'(k * 4), $urandom, '0);
    // R10 read-before-write on one word
    step(1'b1, 12'h204, 32'hCAFE0001, '0);
    step(1'b1, 12'h204, 32'hCAFE0002, '0);
    step(1'b0, 12'h204, 32'd0, '0);

    // R3/R4 range ends
    step(1'b1, 12'h000, 32'hFFFF_FFFF, '0);
    step(1'b1, 12'h004, 32'hFFFF_FC00, '0);
    step(1'b1, 12'h004, 32'h0000_03FF, '0);
    step(1'b1, 12'h000, 32'h0000_0003, '0);
    // R5 enable gate
    step(1'b1, 12'h01C, 32'h0000_0001, '0);
    step(1'b1, 12'h01C, 32'h0000_0800, '0);
    step(1'b1, 12'h01C, 32'h0000_080D, '0);

    // R6/R7/R8 status, clear, set wins, irq
    step(1'b1, 12'h018, 32'h0000_0005, 5'b00111);
    step(1'b0, 12'h024, 32'd0, '0);
    step(1'b0, 12'h000, 32'd0, '0);
    step(1'b1, 12'h028, 32'h0000_0003, 5'b00001);
    chk("R7 set beats clear", 32'(m_stat), 32'h5);
    step(1'b0, 12'h020, 32'd0, '0);
    step(1'b1, 12'h028, 32'h0000_001F, '0);
    step(1'b0, 12'h020, 32'd0, '0);
    step(1'b0, 12'h020, 32'd0, '0);

    // R11 stray writes (status views, current-address views, id, unmapped)
    step(1'b1, 12'h020, 32'hFFFF_FFFF, '0);
    step(1'b1, 12'h02C, 32'h1234_5678, '0);
    step(1'b1, 12'hFE4, 32'hFFFF_FFFF, '0);
    step(1'b1, 12'h800, 32'hFFFF_FFFF, '0);
    step(1'b0, 12'hFE4, 32'd0, '0);
    step(1'b0, 12'h020, 32'd0, '0);
    step(1'b0, 12'h02C, 32'd0, '0);

    // R9 full id sequence
    for (int k = 0; k < 8; k++) step(1'b0, 12'hFE0 + 12'(k * 4), 32'd0, '0);

    // constrained random traffic
    for (int n = 0; n < 3000; n++) begin
      logic [NIRQ-1:0] s = ($urandom % 6 == 0) ? NIRQ'($urandom) : '0;
      step(($urandom % 3) == 0, rand_addr(), $urandom, s);
    end

    // R12 swapped variant
    @(negedge clk); we = 1'b0; sset = '0;
    s_step(1'b1, 12'h018, 32'h0000_0801, "", 32'd0);
    #0 chk("R12 swap enable from 0x18", 32'(s_en), 32'd1);
    s_step(1'b0, 12'h01C, 32'd0, "R12 swap control read", 32'h0000_0801);
    s_step(1'b0, 12'h018, 32'd0, "R12 swap mask untouched", 32'd0);
    s_step(1'b1, 12'h01C, 32'h0000_0003, "", 32'd0);
    s_step(1'b0, 12'h018, 32'd0, "R12 swap mask from 0x1C", 32'd3);
    s_step(1'b0, 12'h01C, 32'd0, "R12 swap control kept", 32'h0000_0801);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule